// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a memory-mapped watchdog. A 32-bit down-counter is decremented on each pulse of a reference-tick enable. Software keeps it from expiring by rewriting the count. A two-bit action field chooses the response when the count reaches zero:

- nothing,
- a level interrupt,
- a level non-maskable interrupt, or
- a single-cycle request to the chip's reset controller.

A status bit records that the watchdog caused the last reset. That bit survives the system reset it triggers. Only a power-on reset clears it.

A write to the count does not take effect at once. It passes through a fixed-latency load stage, and a busy output shows while the load is still in flight. Two registers can be reached over a plain single-cycle bus. Writes are taken on the clock edge. Reads return data combinationally for the address presented.

Top module: `wdog_sentinel`

## Requirements
- R1: After power-on reset the control word (offset 0x0) reads 0x00000000, the count (offset 0x4) reads 0xFFFFFFFF, and irq, nmi, rst_req and load_busy are low.
- R2: While the action field is non-zero, the count drops by one on each clock edge that samples tick high, and stays at zero once it gets there.
- R3: A write to offset 0x4 raises load_busy for exactly LOAD_LAT cycles, after which the written value becomes the count. A second write inside that window restarts it, and the later value wins.
- R4: With action 0 the count does not change except through a completed load, and irq, nmi and rst_req stay low.
- R5: With action 1 (interrupt), irq is high in every cycle in which the count is zero. It is therefore held until a reload lands.
- R6: With action 2 (non-maskable), nmi behaves like irq does under R5, and irq stays low.
- R7: With action 3 (chip reset), rst_req pulses high for one cycle when the count is first seen at zero. The last-reset flag (control bit 31) rises on the same edge.
- R8: Writing action 0 while irq or nmi is high drops that output in the cycle after the write.
- R9: System reset returns the action field to 0 and the count to 0xFFFFFFFF and clears a pending load, but keeps the last-reset flag. Only power-on reset clears the flag.
- R10: A control read returns the action in bits [1:0] and the flag in bit 31, with all other bits zero. Writes to bit 31 and to bits [30:2] have no effect.
- R11: Addresses other than 0x0 and 0x4 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; keeps the last-reset flag |
| tick | input | 1 | Reference-clock tick enable, one clock wide per tick |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt on expiry with action 1 |
| nmi | output | 1 | Level non-maskable interrupt on expiry with action 2 |
| rst_req | output | 1 | One-cycle reset request on expiry with action 3 |
| load_busy | output | 1 | High while a count write is still pending |

## Verification
Control writes appear on bus_rdata, and their effect on irq and nmi shows, one cycle after the write edge. A count write shows up on load_busy at once, but changes the count and clears expiry outputs only LOAD_LAT edges later. A count seen at zero raises rst_req and the flag on the next edge. The bench keeps a behavioural model that it advances on every rising edge from the inputs sampled there. It compares every output against that model at the following falling edge, so each of these latencies is checked in exactly the cycle it is due. Between register writes the bench alternates the read address between the two registers, so the count and the control word are both compared every other cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_TIMER = 4;
    localparam int unsigned FLAG_BIT  = 31;

    typedef enum logic [1:0] {
        ACT_OFF   = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_NMI   = 2'd2,
        ACT_RESET = 2'd3
    } act_e;
endpackage

// File: rtl/wdog_loader.sv
module wdog_loader #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned LAT   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             busy_o,
    output logic             load_o,
    output logic [WIDTH-1:0] val_o
);
    localparam int unsigned CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0]    left;
        logic [WIDTH-1:0] val;
    } ld_st_t;

    ld_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.left = CW'(LAT);
            s_d.val  = data_i;
        end else if (s_q.left != '0) begin
            s_d.left = s_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = (s_q.left != '0);
    assign load_o = (s_q.left == CW'(1));
    assign val_o  = s_q.val;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] count_o,
    output logic             zero_o
);
    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i)
            s_d.count = load_val_i;
        else if (run_i && tick_i && (s_q.count != '0))
            s_d.count = s_q.count - WIDTH'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;
    assign zero_o  = (s_q.count == '0);
endmodule

// File: rtl/wdog_action.sv
module wdog_action
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_e act_i,
    input  logic zero_i,
    output logic irq_o,
    output logic nmi_o,
    output logic rst_req_o,
    output logic req_next_o
);
    typedef struct packed {
        logic fired;
        logic pulse;
    } act_st_t;

    act_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.fired = (act_i == ACT_RESET) && zero_i;
        s_d.pulse = s_d.fired && !s_q.fired;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o      = zero_i && (act_i == ACT_IRQ);
    assign nmi_o      = zero_i && (act_i == ACT_NMI);
    assign rst_req_o  = s_q.pulse;
    assign req_next_o = s_d.pulse;
endmodule

// File: rtl/wdog_sentinel.sv
module wdog_sentinel
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned LOAD_LAT = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              nmi,
    output logic              rst_req,
    output logic              load_busy
);
    localparam int unsigned ACT_W = $bits(act_e);
    localparam int unsigned PAD_W = DATA_W - ACT_W - 1;

    typedef struct packed {
        act_e action;
    } ctrl_st_t;

    logic              rst_all_n;
    logic              sel_ctrl, sel_timer;
    logic              load_fire, cnt_zero, req_next;
    logic [DATA_W-1:0] load_val, cnt_live;
    ctrl_st_t          ctrl_d, ctrl_q;
    logic              flag_d, flag_q;

    assign rst_all_n = por_n & sys_rst_n;
    assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_timer = (bus_addr == ADDR_W'(OFS_TIMER));

    always_comb begin
        ctrl_d = ctrl_q;
        flag_d = flag_q | req_next;
        if (bus_we && sel_ctrl)
            ctrl_d.action = act_e'(bus_wdata[ACT_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) ctrl_q <= '{action: ACT_OFF};
        else            ctrl_q <= ctrl_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    wdog_loader #(.WIDTH(DATA_W), .LAT(LOAD_LAT)) u_loader (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .wr_i   (bus_we && sel_timer),
        .data_i (bus_wdata),
        .busy_o (load_busy),
        .load_o (load_fire),
        .val_o  (load_val)
    );

    wdog_counter #(.WIDTH(DATA_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_all_n),
        .tick_i     (tick),
        .run_i      (ctrl_q.action != ACT_OFF),
        .load_i     (load_fire),
        .load_val_i (load_val),
        .count_o    (cnt_live),
        .zero_o     (cnt_zero)
    );

    wdog_action u_action (
        .clk        (clk),
        .rst_n      (rst_all_n),
        .act_i      (ctrl_q.action),
        .zero_i     (cnt_zero),
        .irq_o      (irq),
        .nmi_o      (nmi),
        .rst_req_o  (rst_req),
        .req_next_o (req_next)
    );

    always_comb begin
        if (sel_ctrl)       bus_rdata = {flag_q, PAD_W'(0), ctrl_q.action};
        else if (sel_timer) bus_rdata = cnt_live;
        else                bus_rdata = '0;
    end
endmodule

// File: rtl/wdog_sentinel_chk.sv
module wdog_sentinel_chk
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_all_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       count,
    input act_e              action,
    input logic              flag,
    input logic              load_fire,
    input logic              irq,
    input logic              nmi,
    input logic              rst_req,
    input logic              load_busy
);
    a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_all_n)
        (bus_we && bus_addr == ADDR_W'(OFS_TIMER)) |=> load_busy);

    a_r2_never_climbs: assert property (@(posedge clk) disable iff (!rst_all_n)
        !load_fire |=> (count <= $past(count)));

    a_r4_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_all_n)
        (action == ACT_OFF && !load_fire) |=> $stable(count));

    a_r6_irq_nmi_exclusive: assert property (@(posedge clk) disable iff (!rst_all_n)
        !(irq && nmi));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_all_n)
        rst_req |=> !rst_req);

    a_r7_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_all_n)
        rst_req |-> flag);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        flag |=> flag);
endmodule

bind wdog_sentinel wdog_sentinel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_all_n (rst_all_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .count     (cnt_live),
    .action    (ctrl_q.action),
    .flag      (flag_q),
    .load_fire (load_fire),
    .irq       (irq),
    .nmi       (nmi),
    .rst_req   (rst_req),
    .load_busy (load_busy)
);

// File: tb/wdog_sentinel_tb.sv
module wdog_sentinel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 3;
    localparam int LAT        = 4;

    logic              clk = 1'b0;
    logic              por_n = 1'b0, sys_rst_n = 1'b1, tick = 1'b1, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq, nmi, rst_req, load_busy;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    tick_toggle = 1'b0;

    logic [31:0] m_count = '1, m_pval = '0;
    int          m_left = 0;
    logic [1:0]  m_act = 2'd0;
    bit          m_flag = 0, m_fired = 0, m_pulse = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_sentinel #(.ADDR_W(ADDR_W), .LOAD_LAT(LAT)) u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .nmi(nmi), .rst_req(rst_req),
        .load_busy(load_busy)
    );

    task automatic model_step();
        logic [31:0] nc;
        bit nfired, npulse;
        if (!por_n || !sys_rst_n) begin
            m_act = 0; m_count = '1; m_left = 0; m_fired = 0; m_pulse = 0;
            if (!por_n) m_flag = 0;
            return;
        end
        nc = m_count;
        if (m_left == 1) nc = m_pval;
        else if (m_act != 0 && tick && m_count != 0) nc = m_count - 1;
        nfired = (m_act == 3) && (m_count == 0);
        npulse = nfired && !m_fired;
        if (bus_we && bus_addr == 3'd4) begin m_left = LAT; m_pval = bus_wdata; end
        else if (m_left > 0) m_left--;
        if (bus_we && bus_addr == 3'd0) m_act = bus_wdata[1:0];
        m_flag  = m_flag | npulse;
        m_count = nc; m_fired = nfired; m_pulse = npulse;
    endtask

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [31:0] er;
        if (bus_addr == 3'd0)      er = {m_flag, 29'd0, m_act};
        else if (bus_addr == 3'd4) er = m_count;
        else                       er = '0;
        check("rdata", bus_rdata, er);
        check("irq", 32'(irq), 32'(m_act == 1 && m_count == 0));
        check("nmi", 32'(nmi), 32'(m_act == 2 && m_count == 0));
        check("rst_req", 32'(rst_req), 32'(m_pulse));
        check("load_busy", 32'(load_busy), 32'(m_left != 0));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        bus_we = 1'b0;
        if (tick_toggle) tick = ~tick;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            bus_addr = (i % 2 == 1) ? 3'd4 : 3'd0;
            cyc();
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        por_n = 1'b1;
        cur_req = "R1"; idle(4);
        cur_req = "R3"; wr(3'd4, 32'd10); idle(6);
        cur_req = "R4"; tick = 1'b1; idle(6);
        cur_req = "R3"; wr(3'd4, 32'd50); idle(2); wr(3'd4, 32'd7); idle(7);
        cur_req = "R2"; wr(3'd0, 32'd1); idle(10);
        cur_req = "R5"; idle(4); wr(3'd4, 32'd3); idle(9);
        cur_req = "R8"; wr(3'd0, 32'd0); idle(3);
        cur_req = "R6"; wr(3'd4, 32'd2); idle(5); wr(3'd0, 32'd2); idle(6);
        cur_req = "R8"; wr(3'd0, 32'd0); idle(2);
        cur_req = "R2"; wr(3'd4, 32'd6); idle(5); wr(3'd0, 32'd1);
        tick_toggle = 1'b1; idle(16); tick_toggle = 1'b0; tick = 1'b1;
        cur_req = "R10"; wr(3'd0, 32'h8000_00F2); idle(2); wr(3'd0, 32'hFFFF_FFFC); idle(2);
        cur_req = "R11"; wr(3'd6, 32'd5); wr(3'd1, 32'd3); wr(3'd2, 32'd9);
        bus_addr = 3'd7; cyc(); bus_addr = 3'd5; cyc(); idle(4);
        cur_req = "R7"; wr(3'd4, 32'd3); idle(5); wr(3'd0, 32'd3); idle(8);
        cur_req = "R9"; sys_rst_n = 1'b0; idle(2); sys_rst_n = 1'b1; idle(4);
        cur_req = "R4"; wr(3'd4, 32'd0); idle(6);
        cur_req = "R9"; por_n = 1'b0; idle(2); por_n = 1'b1; idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule